// File: doc/BRIEF.md
# Synchronous Serial Port with Frame Sync

This block is a full-duplex synchronous serial port running entirely in the machine clock domain. The receive side takes a serial clock, a frame pulse and a data line from outside the chip. It samples them through a synchronizer and shifts data in on each falling edge of the receive clock, most significant bit first. When a word is complete, the receive side moves it into a parallel holding register and raises a ready flag, which software clears by reading. The transmit side takes a parallel word into a holding register. On a frame handshake it copies that word into a shift register and drives one bit on each rising edge of the transmit clock. The data pin is released (output enable low) whenever no word is on the line.

The transmit clock comes from one of two sources, selected by a mode input. It is either an external pin, or a clock the port generates itself at one quarter of the machine clock rate and drives out with its own enable. A framing-mode input chooses between two behaviours. In one, every word needs its own frame pulse. In the other, a single pulse starts an unbroken stream of words: the receiver keeps counting, and the transmitter chains words for as long as its holding register is refilled in time. A width input selects 16-bit or 8-bit words. Configuration inputs are expected to change only while both directions are idle.

Top module: `sync_serial_port`

## Requirements
- R1: Receive bits are sampled on falling edges of the receive clock, most significant bit first, and the finished word appears on rx_data.
- R2: Reception starts at the first falling receive-clock edge where the frame input is low after an edge where it was high, and that edge samples the first bit. In per-word framing, a frame pulse seen while a word is in progress is ignored.
- R3: rx_ready goes to 1 when a word completes and goes to 0 when rx_rd is pulsed. If both happen in the same cycle, rx_ready ends at 1. rx_data changes only when a word completes.
- R4: With cfg_clk_int = 0, transmit timing follows rising edges of tx_clk_in. With cfg_clk_int = 1, it follows tx_clk_out, which has a period of 4 machine clocks (high 2, low 2). tx_clk_oe equals cfg_clk_int delayed by one cycle.
- R5: Transmission starts when the transmit frame input has been seen high at one rising transmit-clock edge and low at a later one, with a word waiting. At that edge the most significant bit is driven, and one further bit is driven per rising edge.
- R6: tx_dat_oe is 1 exactly while a word's bits are on the line. It returns to 0 at the rising edge after the last bit, unless a chained word follows.
- R7: tx_ready is 1 when the holding register is free. tx_wr clears it, and copying into the shift register sets it. If a write and a copy fall in the same cycle, the new word is kept and tx_ready stays 0.
- R8: With cfg_frame_each = 0, words run back to back after one frame pulse. The receiver continues without further pulses. The transmitter chains the next word if one is waiting, and otherwise stops and releases the line.
- R9: cfg_wide = 1 selects 16-bit words. cfg_wide = 0 selects 8-bit words, which send tx_data[7:0] and return rx_data with bits 15:8 at zero.
- R10: After reset, rx_ready = 0, rx_data = 0, tx_ready = 1 and tx_dat_oe = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk_int | input | 1 | 1: port generates transmit clock; 0: taken from tx_clk_in |
| cfg_frame_each | input | 1 | 1: frame pulse per word; 0: continuous words |
| cfg_wide | input | 1 | 1: 16-bit words; 0: 8-bit words |
| rx_clk_pin | input | 1 | External receive serial clock |
| rx_fs_pin | input | 1 | Receive frame pulse |
| rx_dat_pin | input | 1 | Receive serial data |
| rx_rd | input | 1 | Read strobe, clears rx_ready |
| rx_data | output | WORD_W | Last received word |
| rx_ready | output | 1 | Received word waiting |
| tx_clk_in | input | 1 | External transmit serial clock |
| tx_fs_pin | input | 1 | Transmit frame pulse |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_data | input | WORD_W | Word to transmit |
| tx_clk_out | output | 1 | Generated transmit clock |
| tx_clk_oe | output | 1 | Drive enable for tx_clk_out |
| tx_ready | output | 1 | Transmit holding register free |
| tx_dat_out | output | 1 | Serial data out |
| tx_dat_oe | output | 1 | Drive enable for tx_dat_out (0 = high impedance) |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the completion of a received word and a read strobe. The second pair is the copy of the holding register into the transmit shift register and a new write. Each collision is provoked by counting the synchronizer and divider stages, so that rx_rd, or tx_wr, is high exactly at the edge where the port acts. In the receive case, the bench checks that rx_ready ends at 1 and rx_data holds the new word. In the transmit case, it checks that tx_ready stays 0, and that in continuous framing the first word goes out followed, with no gap, by the word written during the collision.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_BUSY  = 2'd2
  } ph_t;
endpackage

// File: rtl/ssp_sync.sv
// Multi-bit level synchronizer for asynchronous serial pins.
module ssp_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] lvl
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= pins;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/ssp_clkdiv.sv
// Free-running divider: output period is 2**DIV_LOG2 machine clocks.
module ssp_clkdiv #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic rise_evt
);
  localparam logic [DIV_LOG2-1:0] PRE_RISE = DIV_LOG2'((1 << (DIV_LOG2 - 1)) - 1);

  logic [DIV_LOG2-1:0] cnt, cnt_nx;

  always_comb begin
    cnt_nx   = cnt + 1'b1;
    rise_evt = (cnt == PRE_RISE);   // sclk rises at this edge
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      sclk <= cnt_nx[DIV_LOG2-1];
    end
  end
endmodule

// File: rtl/ssp_rx.sv
// Receive shifter: one bit per falling serial-clock event.
module ssp_rx import ssp_pkg::*; #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_evt,
  input  logic              fs,
  input  logic              dat,
  input  logic              wide,
  input  logic              frame_each,
  input  logic              rd,
  output logic [WORD_W-1:0] word,
  output logic              ready
);
  localparam int HALF = WORD_W / 2;
  localparam int CW   = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] LEN_W = CW'(WORD_W);
  localparam logic [CW-1:0] LEN_N = CW'(HALF);

  ph_t               ph;
  logic [WORD_W-1:0] sh, sh_nx, done_word;
  logic [CW-1:0]     cnt, len;
  logic              last;

  always_comb begin
    sh_nx     = {sh[WORD_W-2:0], dat};
    len       = wide ? LEN_W : LEN_N;
    last      = (cnt == len - CW'(1));
    done_word = wide ? sh_nx : {{HALF{1'b0}}, sh_nx[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      sh    <= '0;
      cnt   <= '0;
      word  <= '0;
      ready <= 1'b0;
    end else begin
      if (rd) ready <= 1'b0;
      if (bit_evt) begin
        case (ph)
          PH_IDLE:  if (fs) ph <= PH_ARMED;
          PH_ARMED: if (!fs) begin
            sh  <= sh_nx;
            cnt <= CW'(1);
            ph  <= PH_BUSY;
          end
          PH_BUSY: begin
            sh <= sh_nx;
            if (last) begin
              word  <= done_word;
              ready <= 1'b1;                 // wins over rd
              cnt   <= '0;
              if (frame_each) ph <= fs ? PH_ARMED : PH_IDLE;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ssp_tx.sv
// Transmit holding register and shifter: one bit per rising serial-clock event.
module ssp_tx import ssp_pkg::*; #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_evt,
  input  logic              fs,
  input  logic              wide,
  input  logic              frame_each,
  input  logic              wr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              dat,
  output logic              oe,
  output logic              ready
);
  localparam int HALF = WORD_W / 2;
  localparam int CW   = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] LEN_W = CW'(WORD_W);
  localparam logic [CW-1:0] LEN_N = CW'(HALF);

  ph_t               ph;
  logic [WORD_W-1:0] hold_q, sh, aligned;
  logic [CW-1:0]     cnt, len;
  logic              last, full, start_go, chain_go, copy_go;

  always_comb begin
    len      = wide ? LEN_W : LEN_N;
    last     = (cnt == len);
    full     = !ready;
    aligned  = wide ? hold_q : {hold_q[HALF-1:0], {HALF{1'b0}}};
    start_go = (ph == PH_ARMED) && !fs && full;
    chain_go = (ph == PH_BUSY) && last && !frame_each && full;
    copy_go  = bit_evt && (start_go || chain_go);
  end

  assign dat = sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      hold_q <= '0;
      sh     <= '0;
      cnt    <= '0;
      oe     <= 1'b0;
      ready  <= 1'b1;
    end else begin
      if (copy_go) begin
        sh    <= aligned;
        cnt   <= CW'(1);
        oe    <= 1'b1;
        ph    <= PH_BUSY;
        ready <= 1'b1;
      end else if (bit_evt) begin
        case (ph)
          PH_IDLE:  if (fs && full) ph <= PH_ARMED;
          PH_ARMED: if (!fs) ph <= PH_IDLE;
          PH_BUSY: begin
            if (last) begin
              sh  <= '0;
              oe  <= 1'b0;
              cnt <= '0;
              ph  <= (frame_each && fs && full) ? PH_ARMED : PH_IDLE;
            end else begin
              sh  <= {sh[WORD_W-2:0], 1'b0};
              cnt <= cnt + CW'(1);
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
      if (wr) begin                          // write wins over copy
        hold_q <= wr_data;
        ready  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_clk_int,
  input  logic              cfg_frame_each,
  input  logic              cfg_wide,
  input  logic              rx_clk_pin,
  input  logic              rx_fs_pin,
  input  logic              rx_dat_pin,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              tx_clk_in,
  input  logic              tx_fs_pin,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_clk_out,
  output logic              tx_clk_oe,
  output logic              tx_ready,
  output logic              tx_dat_out,
  output logic              tx_dat_oe
);
  localparam int NPIN  = 5;
  localparam int I_RXC = 0;
  localparam int I_RXF = 1;
  localparam int I_RXD = 2;
  localparam int I_TXC = 3;
  localparam int I_TXF = 4;

  logic [NPIN-1:0] pin_raw, pin_lvl;
  logic rxc_prev, txc_prev;
  logic rx_fall, txc_ext_rise, int_rise, tx_evt;

  assign pin_raw = {tx_fs_pin, tx_clk_in, rx_dat_pin, rx_fs_pin, rx_clk_pin};

  ssp_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .pins(pin_raw),
    .lvl (pin_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rxc_prev  <= 1'b0;
      txc_prev  <= 1'b0;
      tx_clk_oe <= 1'b0;
    end else begin
      rxc_prev  <= pin_lvl[I_RXC];
      txc_prev  <= pin_lvl[I_TXC];
      tx_clk_oe <= cfg_clk_int;
    end
  end

  always_comb begin
    rx_fall      = rxc_prev & ~pin_lvl[I_RXC];
    txc_ext_rise = pin_lvl[I_TXC] & ~txc_prev;
    tx_evt       = cfg_clk_int ? int_rise : txc_ext_rise;
  end

  ssp_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk     (clk),
    .rst     (rst),
    .sclk    (tx_clk_out),
    .rise_evt(int_rise)
  );

  ssp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .bit_evt   (rx_fall),
    .fs        (pin_lvl[I_RXF]),
    .dat       (pin_lvl[I_RXD]),
    .wide      (cfg_wide),
    .frame_each(cfg_frame_each),
    .rd        (rx_rd),
    .word      (rx_data),
    .ready     (rx_ready)
  );

  ssp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .bit_evt   (tx_evt),
    .fs        (pin_lvl[I_TXF]),
    .wide      (cfg_wide),
    .frame_each(cfg_frame_each),
    .wr        (tx_wr),
    .wr_data   (tx_data),
    .dat       (tx_dat_out),
    .oe        (tx_dat_oe),
    .ready     (tx_ready)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_clk_int,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              tx_wr,
  input logic              tx_ready,
  input logic              tx_clk_out,
  input logic              tx_clk_oe,
  input logic              tx_dat_out
);
  // R3: a new received word is always accompanied by the ready flag
  p_rxdata_with_ready_r3: assert property (@(posedge clk) disable iff (rst)
    ($changed(rx_data) && !$past(rst)) |-> rx_ready);

  // R7: a write always leaves the holding register occupied
  p_write_fills_r7: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !tx_ready);

  // R7: the transmit flag only drops because of a write
  p_ready_drop_by_write_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_ready) |-> $past(tx_wr));

  // R4: clock drive enable follows the mode one cycle later
  p_clk_oe_mode_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tx_clk_oe == $past(cfg_clk_int)));

  // R4: generated clock holds each level for two machine cycles
  p_div_high_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_clk_out) |=> tx_clk_out);
  p_div_low_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_clk_out) |=> !tx_clk_out);

  // R5: with the generated clock, data moves only on its rising edge
  p_dat_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
    ($changed(tx_dat_out) && $past(cfg_clk_int) && !$past(rst)) |-> $rose(tx_clk_out));
endmodule

bind sync_serial_port ssp_checker #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_clk_int(cfg_clk_int),
  .rx_data    (rx_data),
  .rx_ready   (rx_ready),
  .tx_wr      (tx_wr),
  .tx_ready   (tx_ready),
  .tx_clk_out (tx_clk_out),
  .tx_clk_oe  (tx_clk_oe),
  .tx_dat_out (tx_dat_out)
);

// File: tb/sync_serial_port_test.sv
`timescale 1ns/1ps
module sync_serial_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_clk_int = 1'b0, cfg_frame_each = 1'b1, cfg_wide = 1'b1;
  logic rx_clk_pin = 1'b0, rx_fs_pin = 1'b0, rx_dat_pin = 1'b0, rx_rd = 1'b0;
  logic tx_clk_in = 1'b0, tx_fs_pin = 1'b0, tx_wr = 1'b0;
  logic [15:0] tx_data = '0;
  logic [15:0] rx_data;
  logic rx_ready, tx_clk_out, tx_clk_oe, tx_ready, tx_dat_out, tx_dat_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  sync_serial_port uut (
    .clk(clk), .rst(rst), .cfg_clk_int(cfg_clk_int), .cfg_frame_each(cfg_frame_each),
    .cfg_wide(cfg_wide), .rx_clk_pin(rx_clk_pin), .rx_fs_pin(rx_fs_pin),
    .rx_dat_pin(rx_dat_pin), .rx_rd(rx_rd), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_clk_in(tx_clk_in), .tx_fs_pin(tx_fs_pin), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_clk_out(tx_clk_out), .tx_clk_oe(tx_clk_oe), .tx_ready(tx_ready),
    .tx_dat_out(tx_dat_out), .tx_dat_oe(tx_dat_oe)
  );

  function automatic logic [15:0] exp_word(input logic [15:0] w, input bit wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  function automatic logic bit_at(input logic [15:0] w, input bit wide, input int i);
    return wide ? w[15 - i] : w[7 - i];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    clks(3);
    rst = 1'b0;
    clks(2);
  endtask

  // one receive-clock period; optional read strobe lands on the completion edge
  task automatic rx_cycle(input logic fs, input logic d, input bit collide);
    rx_clk_pin = 1'b1; rx_fs_pin = fs; rx_dat_pin = d;
    clks(8);
    rx_clk_pin = 1'b0;
    if (collide) begin
      repeat (2) @(posedge clk);
      #1 rx_rd = 1'b1;
      @(posedge clk);
      #1 rx_rd = 1'b0;
      clks(5);
    end else begin
      clks(8);
    end
  endtask

  task automatic rx_word(input logic [15:0] w, input bit wide, input bit pulse, input bit collide);
    int n = wide ? 16 : 8;
    if (pulse) rx_cycle(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < n; i++) rx_cycle(1'b0, bit_at(w, wide, i), collide && (i == n - 1));
  endtask

  task automatic read_rx();
    rx_rd = 1'b1; clks(1); rx_rd = 1'b0; clks(1);
  endtask

  task automatic write_tx(input logic [15:0] w);
    tx_data = w; tx_wr = 1'b1; clks(1); tx_wr = 1'b0;
  endtask

  // one external transmit-clock period, sampled late in the high phase
  task automatic tx_ext_cycle(input logic fs, output logic d, output logic o);
    tx_clk_in = 1'b0; tx_fs_pin = fs;
    clks(8);
    tx_clk_in = 1'b1;
    clks(7);
    d = tx_dat_out; o = tx_dat_oe;
    clks(1);
  endtask

  task automatic tx_ext_word(input bit wide, output logic [15:0] got,
                             output bit oe_all, output bit oe_after);
    logic d, o;
    int n = wide ? 16 : 8;
    got = '0; oe_all = 1'b1;
    tx_ext_cycle(1'b1, d, o);
    for (int i = 0; i < n; i++) begin
      tx_ext_cycle(1'b0, d, o);
      got = {got[14:0], d};
      oe_all = oe_all & o;
    end
    tx_ext_cycle(1'b0, d, o);
    oe_after = o;
  endtask

  // generated-clock transmit; optional write collides with the copy edge
  task automatic tx_int_run(input int nbits, input bit collide, input logic [15:0] wb,
                            output logic [31:0] got, output bit oe_all,
                            output bit oe_after, output logic rdy_after_start);
    got = '0; oe_all = 1'b1;
    @(posedge tx_clk_out); #1 tx_fs_pin = 1'b1;
    @(posedge tx_clk_out); #1 tx_fs_pin = 1'b0;
    if (collide) begin
      @(negedge tx_clk_out);
      @(posedge clk); #1 tx_data = wb; tx_wr = 1'b1;
      @(posedge clk); #1 tx_wr = 1'b0;
    end else begin
      @(posedge tx_clk_out); #1;
    end
    rdy_after_start = tx_ready;
    for (int i = 0; i < nbits; i++) begin
      @(negedge tx_clk_out); #1;
      got = {got[30:0], tx_dat_out};
      oe_all = oe_all & tx_dat_oe;
    end
    @(negedge tx_clk_out); #1;
    oe_after = tx_dat_oe;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w, got;
    logic [31:0] got32;
    logic [7:0]  pat;
    bit oe_all, oe_after, wide;
    logic rdy;
    void'($urandom(32'h5eed));

    clks(4);
    rst = 1'b0;
    clks(2);
    // R10 reset state
    check("R10 rx_ready", rx_ready, 0);
    check("R10 rx_data", rx_data, 0);
    check("R10 tx_ready", tx_ready, 1);
    check("R10 tx_dat_oe", tx_dat_oe, 0);

    // R1 16-bit receive, R3 read clears
    cfg_wide = 1'b1; cfg_frame_each = 1'b1;
    rx_word(16'hA5C3, 1'b1, 1'b1, 1'b0);
    check("R1 rx word 16", rx_data, 16'hA5C3);
    check("R3 ready set", rx_ready, 1);
    read_rx();
    check("R3 ready cleared", rx_ready, 0);

    // R9 8-bit receive zero-extended
    cfg_wide = 1'b0;
    rx_word(16'hFF62, 1'b0, 1'b1, 1'b0);
    check("R9 rx word 8", rx_data, 16'h0062);
    read_rx();

    // R2 wide frame pulse, start after its falling edge; mid-word pulse ignored
    rx_cycle(1'b1, 1'b1, 1'b0);
    rx_cycle(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) rx_cycle(i == 4, bit_at(16'h003C, 1'b0, i), 1'b0);
    check("R2 start on frame fall, mid-word pulse ignored", rx_data, 16'h003C);
    check("R2 ready", rx_ready, 1);

    // R3 collision: previous word unread, read strobe on completion edge
    rx_word(16'h0081, 1'b0, 1'b1, 1'b1);
    check("R3 collision ready stays", rx_ready, 1);
    check("R3 collision data", rx_data, 16'h0081);
    read_rx();

    // R8 continuous receive: one pulse, two words
    cfg_frame_each = 1'b0;
    rx_word(16'h005A, 1'b0, 1'b1, 1'b0);
    check("R8 rx first word", rx_data, 16'h005A);
    read_rx();
    rx_word(16'h00C7, 1'b0, 1'b0, 1'b0);
    check("R8 rx second word no pulse", rx_data, 16'h00C7);
    check("R8 rx second ready", rx_ready, 1);
    do_reset();

    // R4 R5 R6 R7 external clock, per-word framing
    cfg_frame_each = 1'b1; cfg_wide = 1'b0; cfg_clk_int = 1'b0;
    clks(2);
    check("R4 clk_oe ext", tx_clk_oe, 0);
    write_tx(16'h1262);
    clks(1);
    check("R7 ready after write", tx_ready, 0);
    tx_ext_word(1'b0, got, oe_all, oe_after);
    check("R5 tx ext 8-bit bits", got, 16'h0062);
    check("R6 oe during word", oe_all, 1);
    check("R6 oe released after", oe_after, 0);
    check("R7 ready after copy", tx_ready, 1);

    // R4 generated clock shape
    cfg_clk_int = 1'b1;
    clks(2);
    check("R4 clk_oe int", tx_clk_oe, 1);
    @(posedge tx_clk_out); #1;
    pat = '0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      pat = {pat[6:0], tx_clk_out};
    end
    check("R4 divide by four", pat, 8'b10011001);

    // R5 R9 generated clock, 16-bit word
    cfg_wide = 1'b1;
    write_tx(16'hB38E);
    tx_int_run(16, 1'b0, 16'h0, got32, oe_all, oe_after, rdy);
    check("R5 tx int 16-bit", got32[15:0], 16'hB38E);
    check("R6 oe int word", oe_all, 1);
    check("R6 oe int released", oe_after, 0);
    check("R7 ready after start", rdy, 1);

    // R7 R8 collision of write with copy, continuous chaining
    cfg_wide = 1'b0; cfg_frame_each = 1'b0;
    write_tx(16'h0062);
    tx_int_run(16, 1'b1, 16'h009D, got32, oe_all, oe_after, rdy);
    check("R7 collision ready stays 0", rdy, 0);
    check("R8 chained words", got32[15:0], 16'h629D);
    check("R8 oe across chain", oe_all, 1);
    check("R8 stop when empty", oe_after, 0);
    check("R7 ready after chain copy", tx_ready, 1);

    // random words on both directions
    cfg_frame_each = 1'b1; cfg_clk_int = 1'b0;
    for (int k = 0; k < 12; k++) begin
      w = 16'($urandom);
      wide = 1'($urandom);
      cfg_wide = wide;
      clks(2);
      rx_word(w, wide, 1'b1, 1'b0);
      check("R1 R9 random rx", rx_data, exp_word(w, wide));
      read_rx();
      write_tx(w);
      tx_ext_word(wide, got, oe_all, oe_after);
      check("R5 R9 random tx", got, exp_word(w, wide));
      check("R6 random oe", {oe_all, oe_after}, 2'b10);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule